// File: doc/BRIEF.md
# Linked-Descriptor XOR Gather Engine

This block combines up to four source buffers with a bitwise XOR and writes the result to one destination buffer. The work is described by a list of descriptors kept in memory. Software loads the address of the first descriptor into a link register and sets an enable bit. The engine then fetches each descriptor in turn, moves the data through a local accumulation buffer, and follows the link field to the next descriptor. A link value of zero marks the last descriptor.

The engine reaches memory through a single word-wide request/response port that allows one outstanding request. This port carries descriptor fetches, source reads and destination writes. Data is handled in blocks the size of the accumulation buffer. For each block the engine reads the first source into the buffer, XORs every further source into it word by word, and then writes the buffer out. Clearing the enable bit pauses the engine wherever it is, and setting it again continues from the same point. Malformed descriptors stop the engine with an error flag. After software clears the flag, it can continue the chain from the descriptor that follows the faulty one.

Top module: `xor_chain_top`

## Requirements
- R1: After reset, the control bits, all status bits, the link register and the current-descriptor register read zero, and no memory request is raised.
- R2: Writing control (cfgAddr 0) with bit0 (enable) set and bit1 (resume) clear, while the engine is idle and no error flag is set, sets status bit0 (active) and clears status bit1 (done). The first request is then a read at the link register address.
- R3: A descriptor is 8 consecutive words, read in ascending address order: word 0 is the link, words 1 to 4 are source addresses 1 to 4, word 5 is the destination address, word 6 is the byte count, and bits [2:0] of word 7 give the source count. Other bits of word 7 are ignored.
- R4: When a descriptor fetch completes, the current-descriptor register takes the address the descriptor was fetched from, and the link register takes the descriptor's link word.
- R5: Destination word i equals the XOR of word i of sources 1 to n. Writes go out in ascending address order, in blocks of at most BUF_DEPTH words, and each write completes at its handshake.
- R6: After the last destination write of a descriptor whose link word is zero, active clears, done sets, and no further descriptor is fetched.
- R7: While enable is clear, no memory request is raised and active stays set. Setting enable again finishes the chain with the same results.
- R8: A byte count that is zero or not a multiple of 4 sets status bit2 and clears active, and that descriptor makes no writes.
- R9: A source count of 0, 5, 6 or 7 sets status bit3 and clears active, and that descriptor makes no writes.
- R10: Writing status (cfgAddr 1) clears each of bits 1 to 3 that is written with 1. A start write is ignored while bit2 or bit3 is set.
- R11: An enable write with resume set, while the engine is idle, fetches the descriptor at the link register address. It is ignored when the link register is zero.
- R12: The port holds at most one read in flight, and a request that is not accepted keeps its address, direction and data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 control, 1 status (write 1 to clear), 2 link |
| cfgWdata | input | DATA_W | Register write data |
| ctrlOut | output | 2 | Control bits: [0] enable, [1] resume |
| statusOut | output | 4 | [0] active, [1] done, [2] count error, [3] source-count error |
| nextDescAddr | output | ADDR_W | Link register: next descriptor address |
| curDescAddr | output | ADDR_W | Address of the descriptor in use |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 for write, 0 for read |
| memReqAddr | output | ADDR_W | Byte address of the word |
| memReqWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Read data |

## Verification
The bench builds the engine with BUF_DEPTH of 4 words and 32-bit addresses and data. With this small depth, descriptors of 6, 8 and 10 words cross one or two block boundaries, so the address advance and the restart of the source loop at each block are exercised with only a few words of data. Requests are accepted in a pattern that stalls every fourth cycle, and one chain runs with requests always accepted. Together these cover held requests, responses that arrive during a pause, and back-to-back transfers.

// File: rtl/xor_chain_pkg.sv
package xor_chain_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FRSP, S_CHECK, S_RREQ, S_RRSP, S_WREQ, S_BLKEND
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fieldLoad;
    logic bufLoad;
    logic bufXor;
    logic advance;
  } dpStrobe_t;

  localparam int DESC_WORDS = 8;
  localparam int F_LINK     = 0;
  localparam int F_SRC0     = 1;
  localparam int F_DST      = 5;
  localparam int F_COUNT    = 6;
  localparam int F_CTL      = 7;
  localparam int MAX_SRC    = 4;

  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_LINK   = 2;

  localparam int ST_ACTIVE  = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_ERRCNT  = 2;
  localparam int ST_ERRSRC  = 3;

endpackage

// File: rtl/xor_chain_dp.sv
module xor_chain_dp
  import xor_chain_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 64,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        fieldIdx,
  input  logic [1:0]        srcSel,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [ADDR_W-1:0] advBytes,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] linkField,
  output logic [ADDR_W-1:0] srcBase,
  output logic [ADDR_W-1:0] dstBase,
  output logic [ADDR_W-1:0] byteCount,
  output logic [2:0]        srcCount,
  output logic [DATA_W-1:0] bufOut
);

  logic [ADDR_W-1:0] srcAddr [MAX_SRC];
  logic [DATA_W-1:0] accBuf  [BUF_DEPTH];

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)
        srcAddr[g] <= '0;
      else if (strobe.fieldLoad && fieldIdx == 3'(F_SRC0 + g))
        srcAddr[g] <= rdData[ADDR_W-1:0];
      else if (strobe.advance)
        srcAddr[g] <= srcAddr[g] + advBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkField <= '0;
      dstBase   <= '0;
      byteCount <= '0;
      srcCount  <= '0;
    end else if (strobe.fieldLoad) begin
      case (fieldIdx)
        3'(F_LINK):  linkField <= rdData[ADDR_W-1:0];
        3'(F_DST):   dstBase   <= rdData[ADDR_W-1:0];
        3'(F_COUNT): byteCount <= rdData[ADDR_W-1:0];
        3'(F_CTL):   srcCount  <= rdData[2:0];
        default: ;
      endcase
    end else if (strobe.advance) begin
      dstBase <= dstBase + advBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.bufLoad)
      accBuf[wordIdx] <= rdData;
    else if (strobe.bufXor)
      accBuf[wordIdx] <= accBuf[wordIdx] ^ rdData;
  end

  assign srcBase = srcAddr[srcSel];
  assign bufOut  = accBuf[wordIdx];

endmodule

// File: rtl/xor_chain_ctrl.sv
module xor_chain_ctrl
  import xor_chain_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 64,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int LEN_W    = IDX_W + 1,
  localparam int ALIGN_W  = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] linkField,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] byteCount,
  input  logic [2:0]        srcCount,
  input  logic [DATA_W-1:0] bufOut,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  output dpStrobe_t         strobe,
  output logic [2:0]        fieldIdx,
  output logic [1:0]        srcSel,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [ADDR_W-1:0] advBytes,
  output logic [1:0]        ctrlOut,
  output logic [3:0]        statusOut,
  output logic [ADDR_W-1:0] nextDescAddr,
  output logic [ADDR_W-1:0] curDescAddr
);

  ctrlState_t        state;
  logic              ctrlEn, ctrlRes;
  logic              done, errCnt, errSrc;
  logic [2:0]        fIdx;
  logic [1:0]        srcIdx;
  logic [IDX_W-1:0]  wIdx;
  logic [LEN_W-1:0]  blkLen;
  logic [ADDR_W-1:0] remWords;
  logic [ADDR_W-1:0] remLeft;
  logic [ADDR_W-1:0] countWords;
  logic              reqFire, lastWord, ctrlWrite, startOk, badSrc, badCnt;

  function automatic logic [LEN_W-1:0] blkOf(input logic [ADDR_W-1:0] rem);
    if (rem >= ADDR_W'(BUF_DEPTH)) return LEN_W'(BUF_DEPTH);
    return rem[LEN_W-1:0];
  endfunction

  assign reqFire    = memReqValid && memReqReady;
  assign lastWord   = (LEN_W'(wIdx) + LEN_W'(1)) == blkLen;
  assign ctrlWrite  = cfgWe && cfgAddr == 2'(REG_CTRL);
  assign startOk    = cfgWdata[0] && !errCnt && !errSrc &&
                      !(cfgWdata[1] && nextDescAddr == '0);
  assign badSrc     = srcCount == 3'd0 || srcCount > 3'(MAX_SRC);
  assign badCnt     = byteCount == '0 || byteCount[ALIGN_W-1:0] != '0;
  assign countWords = byteCount >> ALIGN_W;
  assign remLeft    = remWords - ADDR_W'(blkLen);

  always_comb begin
    memReqValid = ctrlEn && (state == S_FREQ || state == S_RREQ || state == S_WREQ);
    memReqWrite = state == S_WREQ;
    case (state)
      S_FREQ:  memReqAddr = nextDescAddr + (ADDR_W'(fIdx) << ALIGN_W);
      S_WREQ:  memReqAddr = dstBase + (ADDR_W'(wIdx) << ALIGN_W);
      default: memReqAddr = srcBase + (ADDR_W'(wIdx) << ALIGN_W);
    endcase
    memReqWdata      = bufOut;
    strobe.fieldLoad = state == S_FRSP && memRspValid;
    strobe.bufLoad   = state == S_RRSP && memRspValid && srcIdx == 2'd0;
    strobe.bufXor    = state == S_RRSP && memRspValid && srcIdx != 2'd0;
    strobe.advance   = state == S_WREQ && reqFire && lastWord;
    fieldIdx         = fIdx;
    srcSel           = srcIdx;
    wordIdx          = wIdx;
    advBytes         = ADDR_W'(blkLen) << ALIGN_W;
  end

  assign ctrlOut   = {ctrlRes, ctrlEn};
  assign statusOut = {errSrc, errCnt, done, state != S_IDLE};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      ctrlEn       <= 1'b0;
      ctrlRes      <= 1'b0;
      done         <= 1'b0;
      errCnt       <= 1'b0;
      errSrc       <= 1'b0;
      fIdx         <= '0;
      srcIdx       <= '0;
      wIdx         <= '0;
      blkLen       <= '0;
      remWords     <= '0;
      nextDescAddr <= '0;
      curDescAddr  <= '0;
    end else begin
      if (ctrlWrite) begin
        ctrlEn  <= cfgWdata[0];
        ctrlRes <= cfgWdata[1];
      end
      if (cfgWe && cfgAddr == 2'(REG_STATUS)) begin
        if (cfgWdata[ST_DONE])   done   <= 1'b0;
        if (cfgWdata[ST_ERRCNT]) errCnt <= 1'b0;
        if (cfgWdata[ST_ERRSRC]) errSrc <= 1'b0;
      end
      if (cfgWe && cfgAddr == 2'(REG_LINK) && state == S_IDLE)
        nextDescAddr <= cfgWdata[ADDR_W-1:0];

      case (state)
        S_IDLE: begin
          if (ctrlWrite && startOk) begin
            done  <= 1'b0;
            fIdx  <= '0;
            state <= S_FREQ;
          end
        end
        S_FREQ: if (reqFire) state <= S_FRSP;
        S_FRSP: begin
          if (memRspValid) begin
            if (fIdx == 3'(DESC_WORDS - 1)) begin
              curDescAddr  <= nextDescAddr;
              nextDescAddr <= linkField;
              state        <= S_CHECK;
            end else begin
              fIdx  <= fIdx + 3'd1;
              state <= S_FREQ;
            end
          end
        end
        S_CHECK: begin
          if (badSrc || badCnt) begin
            if (badSrc) errSrc <= 1'b1;
            if (badCnt) errCnt <= 1'b1;
            state <= S_IDLE;
          end else begin
            remWords <= countWords;
            blkLen   <= blkOf(countWords);
            srcIdx   <= '0;
            wIdx     <= '0;
            state    <= S_RREQ;
          end
        end
        S_RREQ: if (reqFire) state <= S_RRSP;
        S_RRSP: begin
          if (memRspValid) begin
            if (lastWord) begin
              wIdx <= '0;
              if (srcIdx == srcCount[1:0] - 2'd1) begin
                state <= S_WREQ;
              end else begin
                srcIdx <= srcIdx + 2'd1;
                state  <= S_RREQ;
              end
            end else begin
              wIdx  <= wIdx + IDX_W'(1);
              state <= S_RREQ;
            end
          end
        end
        S_WREQ: begin
          if (reqFire) begin
            if (lastWord) begin
              wIdx  <= '0;
              state <= S_BLKEND;
            end else begin
              wIdx <= wIdx + IDX_W'(1);
            end
          end
        end
        S_BLKEND: begin
          if (remLeft == '0) begin
            if (nextDescAddr == '0) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              fIdx  <= '0;
              state <= S_FREQ;
            end
          end else begin
            remWords <= remLeft;
            blkLen   <= blkOf(remLeft);
            srcIdx   <= '0;
            state    <= S_RREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xor_chain_top.sv
module xor_chain_top
  import xor_chain_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [1:0]        ctrlOut,
  output logic [3:0]        statusOut,
  output logic [ADDR_W-1:0] nextDescAddr,
  output logic [ADDR_W-1:0] curDescAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  dpStrobe_t         strobe;
  logic [2:0]        fieldIdx;
  logic [1:0]        srcSel;
  logic [IDX_W-1:0]  wordIdx;
  logic [ADDR_W-1:0] advBytes, linkField, srcBase, dstBase, byteCount;
  logic [2:0]        srcCount;
  logic [DATA_W-1:0] bufOut;

  xor_chain_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .linkField(linkField), .srcBase(srcBase), .dstBase(dstBase),
    .byteCount(byteCount), .srcCount(srcCount), .bufOut(bufOut),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .strobe(strobe), .fieldIdx(fieldIdx), .srcSel(srcSel),
    .wordIdx(wordIdx), .advBytes(advBytes), .ctrlOut(ctrlOut), .statusOut(statusOut),
    .nextDescAddr(nextDescAddr), .curDescAddr(curDescAddr)
  );

  xor_chain_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fieldIdx(fieldIdx), .srcSel(srcSel),
    .wordIdx(wordIdx), .advBytes(advBytes), .rdData(memRspData),
    .linkField(linkField), .srcBase(srcBase), .dstBase(dstBase),
    .byteCount(byteCount), .srcCount(srcCount), .bufOut(bufOut)
  );

endmodule

// File: rtl/xor_chain_chk.sv
module xor_chain_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        ctrlOut,
  input logic [3:0]        statusOut,
  input logic [ADDR_W-1:0] curDescAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata
);

  a_r12_single_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && !memReqWrite) |=> !memReqValid);

  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (!memReqValid || ($stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWdata))));

  a_r7_paused_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOut[0] |-> !memReqValid);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[0] |-> !memReqValid);

  a_r6_done_not_active: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[1] |-> !statusOut[0]);

  a_r10_error_halts: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[2] || statusOut[3]) |-> !statusOut[0]);

  a_r4_cur_moves_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curDescAddr) |-> statusOut[0]);

endmodule

bind xor_chain_top xor_chain_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlOut(ctrlOut), .statusOut(statusOut),
  .curDescAddr(curDescAddr), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata)
);

// File: tb/test_xor_chain_top.sv
module test_xor_chain_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [1:0]  ctrlOut;
  logic [3:0]  statusOut;
  logic [31:0] nextDescAddr, curDescAddr;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  logic [31:0] mem [0:1023];
  logic [7:0]  rdyCnt = '0;
  logic        fastMode = 1'b0;
  logic [63:0] expQ [$];
  int          testCount = 0, failCount = 0, writesSeen = 0, reqCount = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  xor_chain_top #(.ADDR_W(32), .DATA_W(32), .BUF_DEPTH(4)) i_xor_chain_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .ctrlOut(ctrlOut), .statusOut(statusOut), .nextDescAddr(nextDescAddr),
    .curDescAddr(curDescAddr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // behavioural memory: reads answer one cycle after acceptance
  assign memReqReady = fastMode || (rdyCnt[1:0] != 2'b11);
  always @(posedge clk) begin
    rdyCnt      <= rdyCnt + 8'd1;
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady && !memReqWrite) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[memReqAddr[11:2]];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard of destination writes (R5)
  always @(negedge clk) begin
    if (memReqValid && memReqReady) begin
      reqCount++;
      if (memReqWrite) begin
        writesSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected write addr", memReqAddr, 32'hFFFF_FFFF);
        end else begin
          logic [63:0] e;
          e = expQ.pop_front();
          check(memReqAddr == e[63:32], "R5", "write address", memReqAddr, e[63:32]);
          check(memReqWdata == e[31:0], "R5", "write data", memReqWdata, e[31:0]);
        end
      end
    end
  end

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic buildDesc(input int base, input int link, input int s0, input int s1,
                           input int s2, input int s3, input int dst, input int cnt,
                           input int ctl);
    mem[base/4 + 0] = link; mem[base/4 + 1] = s0; mem[base/4 + 2] = s1;
    mem[base/4 + 3] = s2;   mem[base/4 + 4] = s3; mem[base/4 + 5] = dst;
    mem[base/4 + 6] = cnt;  mem[base/4 + 7] = ctl;
  endtask

  // driver: push the expected destination words
  task automatic pushExpect(input int n, input int s0, input int s1, input int s2,
                            input int s3, input int dst, input int words);
    int src [4];
    src = '{s0, s1, s2, s3};
    for (int i = 0; i < words; i++) begin
      logic [31:0] x;
      x = '0;
      for (int j = 0; j < n; j++) x ^= mem[src[j]/4 + i];
      expQ.push_back({32'(dst + 4*i), x});
    end
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (statusOut[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++; failCount++;
      $display("FAIL R6 watchdog: actual=busy expected=idle");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    repeat (5) @(negedge clk);
    check(statusOut == 4'h0, "R1", "status", 32'(statusOut), 0);
    check(ctrlOut == 2'b0, "R1", "control", 32'(ctrlOut), 0);
    check(nextDescAddr == 0 && curDescAddr == 0, "R1", "addresses", nextDescAddr | curDescAddr, 0);
    check(!memReqValid, "R1", "request", 32'(memReqValid), 0);
    rstN = 1'b1;

    // single descriptor, four sources, six words across two blocks
    buildDesc(32'h040, 0, 32'h400, 32'h440, 32'h480, 32'h4C0, 32'h800, 24, 4);
    pushExpect(4, 32'h400, 32'h440, 32'h480, 32'h4C0, 32'h800, 6);
    cfgWrite(2, 32'h040);
    cfgWrite(0, 32'h1);
    check(statusOut[0] && !statusOut[1], "R2", "active after start", 32'(statusOut), 1);
    check(memReqValid && !memReqWrite && memReqAddr == 32'h040, "R2", "first fetch addr",
          memReqAddr, 32'h040);
    w0 = writesSeen;
    waitIdle();
    check(statusOut == 4'b0010, "R6", "done status", 32'(statusOut), 2);
    check(curDescAddr == 32'h040, "R4", "current desc", curDescAddr, 32'h040);
    check(nextDescAddr == 0, "R4", "link reg", nextDescAddr, 0);
    check(writesSeen - w0 == 6 && expQ.size() == 0, "R3", "descriptor words used",
          32'(writesSeen - w0), 6);
    cfgWrite(1, 32'h2);
    check(statusOut == 4'b0000, "R10", "done cleared by write-one", 32'(statusOut), 0);

    // two-descriptor chain, ready always high, extra control bits ignored
    fastMode = 1'b1;
    buildDesc(32'h080, 32'h0C0, 32'h500, 0, 0, 0, 32'h900, 32, 1);
    buildDesc(32'h0C0, 0, 32'h540, 32'h580, 32'h5C0, 0, 32'hA00, 12, 32'hF3);
    pushExpect(1, 32'h500, 0, 0, 0, 32'h900, 8);
    pushExpect(3, 32'h540, 32'h580, 32'h5C0, 0, 32'hA00, 3);
    cfgWrite(2, 32'h080);
    cfgWrite(0, 32'h1);
    waitIdle();
    check(curDescAddr == 32'h0C0, "R4", "current desc after chain", curDescAddr, 32'h0C0);
    check(statusOut == 4'b0010 && expQ.size() == 0, "R6", "chain finished", 32'(statusOut), 2);
    fastMode = 1'b0;

    // pause and continue
    buildDesc(32'h100, 0, 32'h600, 32'h640, 0, 0, 32'hB00, 40, 2);
    pushExpect(2, 32'h600, 32'h640, 0, 0, 32'hB00, 10);
    cfgWrite(2, 32'h100);
    cfgWrite(0, 32'h1);
    repeat (20) @(negedge clk);
    cfgWrite(0, 32'h0);
    r0 = reqCount;
    repeat (40) @(negedge clk);
    check(reqCount == r0, "R7", "no requests while paused", 32'(reqCount - r0), 0);
    check(statusOut[0], "R7", "still active while paused", 32'(statusOut), 1);
    cfgWrite(0, 32'h1);
    waitIdle();
    check(statusOut == 4'b0010 && expQ.size() == 0, "R7", "finished after continue",
          32'(statusOut), 2);

    // bad byte count, then resume past it
    buildDesc(32'h140, 32'h180, 32'h400, 0, 0, 0, 32'hC00, 6, 1);
    buildDesc(32'h180, 0, 32'h400, 32'h440, 0, 0, 32'hC40, 8, 2);
    cfgWrite(2, 32'h140);
    w0 = writesSeen;
    cfgWrite(0, 32'h1);
    waitIdle();
    check(statusOut == 4'b0100, "R8", "count error flag", 32'(statusOut), 4);
    check(writesSeen == w0, "R8", "no writes", 32'(writesSeen - w0), 0);
    check(nextDescAddr == 32'h180, "R4", "link after bad desc", nextDescAddr, 32'h180);
    cfgWrite(0, 32'h1);
    repeat (3) @(negedge clk);
    check(!statusOut[0] && !memReqValid, "R10", "start ignored with error", 32'(statusOut), 4);
    cfgWrite(1, 32'h4);
    check(statusOut == 4'b0000, "R10", "error cleared", 32'(statusOut), 0);
    pushExpect(2, 32'h400, 32'h440, 0, 0, 32'hC40, 2);
    cfgWrite(0, 32'h3);
    check(memReqValid && memReqAddr == 32'h180, "R11", "resume fetch addr", memReqAddr, 32'h180);
    waitIdle();
    check(curDescAddr == 32'h180 && expQ.size() == 0, "R11", "resumed desc",
          curDescAddr, 32'h180);

    // bad source counts
    buildDesc(32'h1C0, 0, 32'h400, 0, 0, 0, 32'hD00, 8, 5);
    cfgWrite(2, 32'h1C0);
    w0 = writesSeen;
    cfgWrite(0, 32'h1);
    waitIdle();
    check(statusOut == 4'b1000 && writesSeen == w0, "R9", "five sources", 32'(statusOut), 8);
    cfgWrite(1, 32'h8);
    buildDesc(32'h200, 0, 32'h400, 0, 0, 0, 32'hD00, 8, 0);
    cfgWrite(2, 32'h200);
    cfgWrite(0, 32'h1);
    waitIdle();
    check(statusOut == 4'b1000 && writesSeen == w0, "R9", "zero sources", 32'(statusOut), 8);
    cfgWrite(1, 32'hE);
    check(statusOut == 4'b0000, "R10", "all flags cleared", 32'(statusOut), 0);

    // resume with empty link
    cfgWrite(0, 32'h3);
    repeat (3) @(negedge clk);
    check(!statusOut[0] && !memReqValid, "R11", "resume ignored at null link",
          32'(statusOut), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule